// File: doc/BRIEF.md
# Two-Tone NRZI Audio Modulator

This block converts a packet stored in an external byte buffer into a stream of 8-bit unsigned audio samples. The samples alternate between a mark tone and a space tone. A 16-bit phase accumulator drives a 512-entry sine table. The table contents are computed when the design is elaborated. Data bits are line-coded as NRZI:
- a zero bit swaps the phase increment between its two values;
- a one bit keeps the current tone.

Because only the increment changes, the waveform stays phase-continuous across bit boundaries.

The host supplies the packet length in bits and pulses `start`. The block raises `busy` and `ptt` and then works from an external sample-rate tick, normally one tick per 256 system clocks. It reads bytes on demand through a read port with one cycle of latency and sends each byte out least significant bit first. Every bit lasts a fixed number of ticks. On the first tick after the last bit, the block drops `busy` and `ptt` and parks the output at mid-scale.

Top module: `afsk_nrzi_mod`

## Requirements
- R1: After reset, and whenever idle, `busy`, `ptt`, `sample_valid` and `rd_en` are low and `sample` holds 0x80.
- R2: A `start` pulse while idle latches `pkt_bits` and sets the increment to 1800 and the accumulator to 0. `busy` and `ptt` are high from the next clock.
- R3: A `start` pulse while busy is ignored: the length and the running waveform carry on unchanged.
- R4: On the first tick of a bit whose index is a multiple of 8, `rd_en` is high in that tick cycle, with `rd_addr` = bit index / 8. On every other cycle `rd_en` is low.
- R5: Bits are taken from each byte least significant bit first. Bit i of the packet is bit (i mod 8) of byte i/8.
- R6: On the first tick of each bit, a 0 bit swaps the increment between 1800 and 2200, and a 1 bit leaves it unchanged.
- R7: Each sample tick first adds the increment to the 16-bit accumulator, modulo 2^16. The new accumulator's bits [15:7] then index the table.
- R8: Table entry k is within 2 of 127.5 + 127.5·sin(2πk/512). Entry 128 is 255 and entry 384 is 0.
- R9: Every bit lasts exactly 36 ticks, so a packet of L bits yields exactly 36·L samples.
- R10: `sample_valid` is a single-clock pulse two clocks after each producing tick. `sample` holds its value between pulses.
- R11: The first tick with bit index equal to the length ends the run. No sample is produced, `busy` and `ptt` fall at that edge, and `sample` returns to 0x80.
- R12: A zero-length start holds `busy` for one tick only and produces no sample and no read.
- R13: Ticks while idle produce no read and no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-clock request to begin a packet |
| pkt_bits | input | 16 | Packet length in bits, latched on an accepted start |
| tick | input | 1 | One-clock sample-rate strobe |
| rd_en | output | 1 | Byte read request, valid in the tick cycle |
| rd_addr | output | 13 | Byte address of the read request |
| rd_data | input | 8 | Byte returned one clock after the request |
| sample | output | 8 | Unsigned audio sample, held between updates |
| sample_valid | output | 1 | One-clock pulse when `sample` is updated |
| busy | output | 1 | High while a packet is being sent |
| ptt | output | 1 | Transmitter key, high while a packet is being sent |

## Verification
- `rd_en` and `rd_addr` are combinational in the tick cycle, so the bench reads them one time unit after raising `tick`, well before the capturing edge.
- A produced sample passes through the fetch-completion cycle and the output register. The bench therefore looks for `sample_valid` and the new value at the falling edge two clocks after the tick edge.
- One clock later, the bench confirms that the strobe has dropped and the value is held.
- `busy`, `ptt` and the 0x80 rest level come from a single edge, so they are checked at the falling edge just after the start or terminating tick.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EMIT = 2'd2
  } mod_state_t;

  // Rational approximation of one sine period over 2^idx_w entries,
  // offset to an unsigned range of samp_w bits.
  function automatic int sine_entry(int i, int idx_w, int samp_w);
    longint half;
    longint k;
    longint p;
    longint den;
    longint up;
    longint dn;
    longint q;
    longint v;
    half = longint'(1) << (idx_w - 1);
    k    = longint'(i) % half;
    p    = k * (half - k);
    den  = 5 * half * half - 4 * p;
    up   = longint'(1) << (samp_w - 1);
    dn   = up - 1;
    if (longint'(i) < half) begin
      q = (up * 16 * p + den / 2) / den;
      v = dn + q;
      if (v > 2 * up - 1) v = 2 * up - 1;
    end else begin
      q = (dn * 16 * p + den / 2) / den;
      v = dn - q;
      if (v < 0) v = 0;
    end
    return int'(v);
  endfunction

endpackage

// File: rtl/afsk_sine_rom.sv
module afsk_sine_rom #(
  parameter int IDX_W  = 9,
  parameter int SAMP_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [SAMP_W-1:0] val
);
  localparam int DEPTH = 1 << IDX_W;

  logic [SAMP_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [SAMP_W-1:0] ENTRY = SAMP_W'(afsk_pkg::sine_entry(g, IDX_W, SAMP_W));
    assign tbl[g] = ENTRY;
  end

  assign val = tbl[idx];
endmodule

// File: rtl/afsk_nco.sv
module afsk_nco #(
  parameter int ACC_W     = 16,
  parameter int IDX_W     = 9,
  parameter int SAMP_W    = 8,
  parameter int INC_MARK  = 1800,
  parameter int INC_SPACE = 2200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              toggle,
  input  logic              rest,
  output logic [SAMP_W-1:0] sample,
  output logic              sample_valid
);
  localparam logic [ACC_W-1:0]  MARK_V = ACC_W'(INC_MARK);
  localparam logic [ACC_W-1:0]  SPC_V  = ACC_W'(INC_SPACE);
  localparam logic [ACC_W-1:0]  SWAP_V = MARK_V ^ SPC_V;
  localparam logic [SAMP_W-1:0] REST_V = {1'b1, {(SAMP_W-1){1'b0}}};

  logic [ACC_W-1:0]  phase_q, phase_d, inc_q, inc_d, inc_step, phase_step;
  logic [SAMP_W-1:0] samp_q, samp_d, rom_val;
  logic              vld_q, vld_d;

  assign inc_step   = toggle ? (inc_q ^ SWAP_V) : inc_q;
  assign phase_step = phase_q + inc_step;

  afsk_sine_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_rom (
    .idx (phase_step[ACC_W-1 -: IDX_W]),
    .val (rom_val)
  );

  always_comb begin
    phase_d = phase_q;
    inc_d   = inc_q;
    samp_d  = samp_q;
    vld_d   = 1'b0;
    if (load) begin
      phase_d = '0;
      inc_d   = MARK_V;
    end else if (step) begin
      inc_d   = inc_step;
      phase_d = phase_step;
      samp_d  = rom_val;
      vld_d   = 1'b1;
    end
    if (rest) samp_d = REST_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      inc_q   <= MARK_V;
      samp_q  <= REST_V;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      inc_q   <= inc_d;
      samp_q  <= samp_d;
      vld_q   <= vld_d;
    end
  end

  assign sample       = samp_q;
  assign sample_valid = vld_q;

  // R6: the increment only ever takes one of the two tone values
  p_inc_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == MARK_V) || (inc_q == SPC_V));

  // R10: the valid strobe never lasts longer than one clock
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/afsk_nrzi_mod.sv
module afsk_nrzi_mod #(
  parameter int ACC_W     = 16,
  parameter int IDX_W     = 9,
  parameter int SAMP_W    = 8,
  parameter int LEN_W     = 16,
  parameter int BIT_TICKS = 36,
  parameter int INC_MARK  = 1800,
  parameter int INC_SPACE = 2200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LEN_W-1:0]     pkt_bits,
  input  logic                 tick,
  output logic                 rd_en,
  output logic [LEN_W-4:0]     rd_addr,
  input  logic [7:0]           rd_data,
  output logic [SAMP_W-1:0]    sample,
  output logic                 sample_valid,
  output logic                 busy,
  output logic                 ptt
);
  import afsk_pkg::*;

  localparam int CNT_W = $clog2(BIT_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_TICKS - 1);
  localparam logic [SAMP_W-1:0] REST_V = {1'b1, {(SAMP_W-1){1'b0}}};

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mod_state_t       state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d, bit_q, bit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             fetch_q, fetch_d, newbit_q, newbit_d;
  logic             load, step, toggle, rest, cur_bit, at_end, fetch_now;

  assign at_end    = (bit_q == len_q);
  assign fetch_now = (cnt_q == '0) && (bit_q[2:0] == 3'd0);
  assign cur_bit   = fetch_q ? rd_data[0] : shreg_q[1];

  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    bit_d    = bit_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    fetch_d  = fetch_q;
    newbit_d = newbit_q;
    load     = 1'b0;
    step     = 1'b0;
    toggle   = 1'b0;
    rest     = 1'b0;
    rd_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          len_d   = pkt_bits;
          bit_d   = '0;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (at_end) begin
            rest    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            rd_en    = fetch_now;
            fetch_d  = fetch_now;
            newbit_d = (cnt_q == '0);
            state_d  = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        step   = 1'b1;
        toggle = newbit_q & ~cur_bit;
        if (newbit_q) shreg_d = fetch_q ? rd_data : {1'b0, shreg_q[7:1]};
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          bit_d = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      len_q    <= '0;
      bit_q    <= '0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      fetch_q  <= 1'b0;
      newbit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      len_q    <= len_d;
      bit_q    <= bit_d;
      cnt_q    <= cnt_d;
      shreg_q  <= shreg_d;
      fetch_q  <= fetch_d;
      newbit_q <= newbit_d;
    end
  end

  afsk_nco #(
    .ACC_W(ACC_W), .IDX_W(IDX_W), .SAMP_W(SAMP_W),
    .INC_MARK(INC_MARK), .INC_SPACE(INC_SPACE)
  ) u_nco (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load         (load),
    .step         (step),
    .toggle       (toggle),
    .rest         (rest),
    .sample       (sample),
    .sample_valid (sample_valid)
  );

  assign rd_addr = bit_q[LEN_W-1:3];
  assign busy    = (state_q != ST_IDLE);
  assign ptt     = busy;

  // R1/R11: the oscillator output sits at mid-scale whenever the sequencer is idle
  p_rest_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (sample == REST_V));

  // R3: a start seen mid-packet leaves the latched length alone
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> $stable(len_q));

  // R4: reads are only requested on a tick of an active packet
  p_fetch_in_run_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |-> (busy && tick));

  // R9: the per-bit tick counter stays inside one bit period
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_q <= CNT_LAST);

  // R10: samples are only produced while a packet is active
  p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample_valid |-> busy);
endmodule

// File: tb/afsk_nrzi_mod_test.sv
module afsk_nrzi_mod_test;
  logic        clk = 1'b0;
  logic        rst_n, start, tick, rd_en, sample_valid, busy, ptt;
  logic [15:0] pkt_bits;
  logic [12:0] rd_addr;
  logic [7:0]  rd_data, sample;
  logic [7:0]  mem [0:15];

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  afsk_nrzi_mod uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_bits(pkt_bits), .tick(tick),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sample(sample),
    .sample_valid(sample_valid), .busy(busy), .ptt(ptt)
  );

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[3:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit near_sine(input int got, input int idx);
    real e;
    e = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * real'(idx) / 512.0);
    return (real'(got) - e <= 2.0) && (e - real'(got) <= 2.0);
  endfunction

  task automatic pulse_start(input int len);
    @(negedge clk);
    pkt_bits = 16'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // one tick; returns strobe/value two clocks later and whether it held a clock after
  task automatic do_tick(output bit v, output int s, output bit f, output int a,
                         output bit held);
    @(negedge clk);
    tick = 1'b1;
    #1;
    f = rd_en;
    a = int'(rd_addr);
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    v = sample_valid;
    s = int'(sample);
    @(negedge clk);
    held = !sample_valid && (int'(sample) == s);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; tick = 1'b0; pkt_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !ptt, "R1", "busy/ptt after reset", int'(busy), 0);
    check(!sample_valid && !rd_en, "R1", "strobes after reset", int'(sample_valid), 0);
    check(sample == 8'h80, "R1", "rest sample", int'(sample), 128);
  endtask

  task automatic t_idle_ticks;
    bit v, f, h; int s, a;
    for (int i = 0; i < 3; i++) begin
      do_tick(v, s, f, a, h);
      check(!v && !f, "R13", "idle tick activity", int'(v) + int'(f), 0);
      check(s == 128 && !busy, "R13", "idle sample", s, 128);
    end
  endtask

  task automatic t_zero_len;
    bit v, f, h; int s, a;
    pulse_start(0);
    check(busy && ptt, "R12", "busy after zero-length start", int'(busy), 1);
    do_tick(v, s, f, a, h);
    check(!v && !f, "R12", "zero-length emits nothing", int'(v) + int'(f), 0);
    check(!busy && !ptt && s == 128, "R12", "idle after one tick", int'(busy), 0);
  endtask

  task automatic run_packet(input string name, input int len, input bit mid_start);
    int bit_i = 0, cnt = 0, inc = 1800, samples = 0, tick_no = 0, idx, s, a;
    logic [7:0]  cur = '0;
    logic [15:0] ph = '0;
    bit v, f, h, exp_fetch;
    pulse_start(len);
    check(busy && ptt, "R2", {name, " busy/ptt after start"}, int'(busy), 1);
    forever begin
      if (mid_start && tick_no == 40) begin
        pulse_start(3);
        check(busy, "R3", {name, " still busy after ignored start"}, int'(busy), 1);
      end
      exp_fetch = (bit_i != len) && (cnt == 0) && (bit_i % 8 == 0);
      do_tick(v, s, f, a, h);
      if (bit_i == len) begin
        check(!v, "R11", {name, " no sample on end tick"}, int'(v), 0);
        check(!busy && !ptt, "R11", {name, " busy/ptt drop"}, int'(busy), 0);
        check(s == 128, "R11", {name, " rest level"}, s, 128);
        break;
      end
      check(f == exp_fetch, "R4", {name, " read request"}, int'(f), int'(exp_fetch));
      if (exp_fetch) check(a == bit_i / 8, "R4", {name, " read address"}, a, bit_i / 8);
      if (cnt == 0) begin
        if (bit_i % 8 == 0) cur = mem[bit_i / 8];
        else cur = cur >> 1;
        if (cur[0] == 1'b0) inc = inc ^ (1800 ^ 2200);
      end
      ph  = ph + 16'(inc);
      idx = int'(ph[15:7]);
      check(v, "R10", {name, " valid two clocks after tick"}, int'(v), 1);
      check(near_sine(s, idx), "R5/R6/R7/R8", {name, " sample value"}, s, idx);
      check(h, "R10", {name, " one-clock strobe, value held"}, int'(h), 1);
      samples++;
      cnt++;
      if (cnt == 36) begin
        cnt = 0;
        bit_i++;
      end
      tick_no++;
    end
    check(samples == len * 36, "R9", {name, " sample count"}, samples, len * 36);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    t_reset();
    t_idle_ticks();
    t_zero_len();
    mem[0] = 8'hFF;
    run_packet("ones", 8, 1'b0);
    mem[0] = 8'hA5; mem[1] = 8'h3C;
    run_packet("mixed", 13, 1'b0);
    mem[0] = 8'h00; mem[1] = 8'h00;
    run_packet("zeros", 10, 1'b1);
    mem[0] = 8'h01; mem[1] = 8'h80; mem[2] = 8'h7E;
    run_packet("edges", 24, 1'b0);
    t_idle_ticks();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule